// File: doc/BRIEF.md
# Accelerator Engine Command and Completion Register Unit

This unit sits between a 64-bit register bus and three engines of an accelerator: a read-DMA engine, a write-DMA engine and an algorithm engine. Software writes one shared control word. Some of its fields are plain storage. Others are command bits that act once and never stay set. A command either starts an engine, clears an engine, removes the algorithm's done status only, or rearms all status tracking. The unit turns each accepted command into a one-cycle pulse toward the engine.

Each engine reports completion with a one-cycle done pulse. The unit keeps a small state machine per engine and shows its state in a read-only status word. The DMA trackers have the states DMA_IDLE, DMA_BUSY and DMA_DONE. The algorithm tracker has ALG_IDLE, ALG_RUN, ALG_WAIT and ALG_DONE. A done event is sticky, and only an explicit clear command or a rearm removes it. Every sticky done bit, when its enable in the control word is set, drives a single level interrupt. The algorithm engine can also send a one-cycle notification when its done status is captured.

The transitions, in priority order, are:
- rearm: any state goes to IDLE.
- done event: any state goes to DONE.
- engine clear: any state goes to IDLE.
- Algorithm done-clear: ALG_DONE goes to ALG_IDLE.
- DMA start: DMA_IDLE goes to DMA_BUSY.
- Algorithm start: ALG_IDLE goes to ALG_RUN, or to ALG_WAIT while stall is high.
- Algorithm stall: ALG_RUN goes to ALG_WAIT.
- Algorithm unstall: ALG_WAIT goes to ALG_RUN.
- Any other input leaves the state unchanged.

Top module: `eng_csr_unit`

## Requirements
- R1: After reset, the control word reads 0, the status word reads 0, irq_o is 0, and the eng_go_o, eng_clr_o and alg_notify_o outputs are all 0.
- R2: A write to control offset 0x20 stores these fields, which read back unchanged: bits 1:0, 8:4 and 27:20, the interrupt enables (42 read-DMA, 43 write-DMA, 46 algorithm) and the algorithm notify enable (45). Every other bit of the control word reads 0.
- R3: Control bits 36, 37 and 38 raise eng_go_o[0] (read-DMA), eng_go_o[1] (write-DMA) and eng_go_o[2] (algorithm) for exactly the one cycle after the write.
- R4: A start moves an idle DMA engine to busy. The status word shows read-DMA busy at bit 41 and write-DMA busy at bit 44. The busy bit stays set until a done event, a clear or a rearm. A start while the engine is busy or done changes nothing.
- R5: A pulse on eng_done_i[0], [1] or [2] sets the sticky done bit at status bit 42, 45 or 48 and removes busy. The done bit is set even when the start arrives in the same cycle, and it stays set until a clear or a rearm.
- R6: Control bits 39, 40 and 41 pulse eng_clr_o[0], [1] and [2] for the one cycle after the write. They return that engine's tracking to idle, unless a done event arrives in the same cycle; the done event wins.
- R7: Control bit 51 returns the algorithm tracking from done to idle without any eng_clr_o pulse. In any other state it has no effect.
- R8: The algorithm status shows running at bit 47 and waiting at bit 46. At most one of bits 46, 47 and 48 is set. A start enters waiting while alg_stall_i is high, and the state then follows alg_stall_i between running and waiting.
- R9: irq_o is high exactly while some done bit is set together with its enable. irq_o stays high until that done bit is cleared or the enable is written to 0.
- R10: alg_notify_o pulses for one cycle, in the cycle the algorithm done bit first appears, when control bit 45 was already stored before the done event.
- R11: Control bit 33 returns every tracker to idle in one cycle and wins over done events in that cycle. By itself it pulses no eng_go_o or eng_clr_o output.
- R12: Writes to any offset other than 0x20, including the status offset 0x08, change nothing. Reads of offset 0x08 return the status word, and reads of any offset other than 0x08 and 0x20 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Register write strobe, one write per cycle |
| bus_addr_i | input | ADDR_W | Byte offset of the register access |
| bus_wdata_i | input | 64 | Write data |
| bus_rdata_o | output | 64 | Read data for bus_addr_i, combinational |
| eng_done_i | input | 3 | Done pulses {algorithm, write-DMA, read-DMA} |
| alg_stall_i | input | 1 | Algorithm engine is waiting for data (level) |
| eng_go_o | output | 3 | Start pulses {algorithm, write-DMA, read-DMA} |
| eng_clr_o | output | 3 | Engine clear pulses {algorithm, write-DMA, read-DMA} |
| alg_notify_o | output | 1 | One-cycle algorithm completion notification |
| irq_o | output | 1 | Completion interrupt level |

## Verification
The assertions take the following for granted:
- Done inputs are single-cycle pulses that follow the engine's own timing.
- The bus offers at most one write per cycle, with stable address and data.
- alg_stall_i is meaningful only while the algorithm engine runs.

The stimulus pulses eng_done_i for one cycle at a time, at random points relative to starts and clears, so that done events also fall in the same cycle as a start, a clear or a rearm. alg_stall_i is toggled freely because the tracker only looks at it in ALG_RUN, ALG_WAIT and on a start. Bus writes are spread over the control offset, the status offset and an unmapped offset.

// File: rtl/eng_csr_pkg.sv
package eng_csr_pkg;

    localparam int WORD_W  = 64;
    localparam int NUM_ENG = 3;            // 0 read-DMA, 1 write-DMA, 2 algorithm
    localparam int NUM_DMA = 2;
    localparam int ALG_IDX = NUM_DMA;

    // control word command bits (self clearing)
    localparam int C_REARM    = 33;
    localparam int C_GO_BASE  = 36;        // +engine index
    localparam int C_CLR_BASE = 39;        // +engine index
    localparam int C_ALG_DCLR = 51;

    // control word enables (stored)
    localparam int C_DMA_IEN_BASE = 42;    // +DMA index
    localparam int C_ALG_NEN      = 45;
    localparam int C_ALG_IEN      = 46;

    // bits of the control word kept as storage
    localparam logic [WORD_W-1:0] CTRL_KEEP_MASK = 64'h0000_6C00_0FF0_01F3;

    // status word layout
    localparam int S_DMA_BUSY_BASE = 41;   // +3*DMA index
    localparam int S_DMA_DONE_BASE = 42;   // +3*DMA index
    localparam int S_DMA_STRIDE    = 3;
    localparam int S_ALG_WAIT      = 46;
    localparam int S_ALG_RUN       = 47;
    localparam int S_ALG_DONE      = 48;

    typedef enum logic [1:0] {
        DMA_IDLE = 2'd0,
        DMA_BUSY = 2'd1,
        DMA_DONE = 2'd2
    } dma_state_t;

    typedef enum logic [1:0] {
        ALG_IDLE = 2'd0,
        ALG_RUN  = 2'd1,
        ALG_WAIT = 2'd2,
        ALG_DONE = 2'd3
    } alg_state_t;

    typedef struct packed {
        logic [NUM_ENG-1:0] go;
        logic [NUM_ENG-1:0] clr;
        logic               done_clr;
        logic               rearm;
    } csr_cmd_t;

endpackage

// File: rtl/ecs_ctrl_reg.sv
module ecs_ctrl_reg
    import eng_csr_pkg::*;
#(
    parameter int          ADDR_W   = 12,
    parameter int unsigned CTRL_OFF = 32'h20
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_wr,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [WORD_W-1:0]             bus_wdata,
    output logic [WORD_W-1:0]             ctrl_q,
    output csr_cmd_t                      cmd,
    output logic [NUM_ENG-1:0]            go_q,
    output logic [NUM_ENG-1:0]            clr_q
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFF);

    logic ctrl_wr;

    assign ctrl_wr = bus_wr && (bus_addr == CTRL_A);

    // command decode in the write cycle
    for (genvar e = 0; e < NUM_ENG; e++) begin : g_cmd
        assign cmd.go[e]  = ctrl_wr && bus_wdata[C_GO_BASE + e];
        assign cmd.clr[e] = ctrl_wr && bus_wdata[C_CLR_BASE + e];
    end
    assign cmd.done_clr = ctrl_wr && bus_wdata[C_ALG_DCLR];
    assign cmd.rearm    = ctrl_wr && bus_wdata[C_REARM];

    // stored fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= bus_wdata & CTRL_KEEP_MASK;
        end
    end

    // one-cycle pulses toward the engines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q  <= '0;
            clr_q <= '0;
        end else begin
            go_q  <= cmd.go;
            clr_q <= cmd.clr;
        end
    end

endmodule

// File: rtl/ecs_dma_track.sv
module ecs_dma_track
    import eng_csr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic clr,
    input  logic done_ev,
    input  logic rearm,
    output logic busy,
    output logic done
);

    dma_state_t cur, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) cur <= DMA_IDLE;
        else        cur <= nxt;
    end

    always_comb begin
        nxt = cur;
        if (rearm) begin
            nxt = DMA_IDLE;
        end else if (done_ev) begin
            nxt = DMA_DONE;
        end else if (clr) begin
            nxt = DMA_IDLE;
        end else begin
            unique case (cur)
                DMA_IDLE: if (go) nxt = DMA_BUSY;
                DMA_BUSY: nxt = DMA_BUSY;
                DMA_DONE: nxt = DMA_DONE;
                default:  nxt = DMA_IDLE;
            endcase
        end
    end

    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (cur)
            DMA_IDLE: ;
            DMA_BUSY: busy = 1'b1;
            DMA_DONE: done = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/ecs_alg_track.sv
module ecs_alg_track
    import eng_csr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic clr,
    input  logic done_clr,
    input  logic done_ev,
    input  logic stall,
    input  logic rearm,
    input  logic notify_en,
    output logic run,
    output logic waiting,
    output logic done,
    output logic notify
);

    alg_state_t cur, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur    <= ALG_IDLE;
            notify <= 1'b0;
        end else begin
            cur    <= nxt;
            notify <= notify_en && (nxt == ALG_DONE) && (cur != ALG_DONE);
        end
    end

    always_comb begin
        nxt = cur;
        if (rearm) begin
            nxt = ALG_IDLE;
        end else if (done_ev) begin
            nxt = ALG_DONE;
        end else if (clr) begin
            nxt = ALG_IDLE;
        end else begin
            unique case (cur)
                ALG_IDLE: if (go)       nxt = stall ? ALG_WAIT : ALG_RUN;
                ALG_RUN:  if (stall)    nxt = ALG_WAIT;
                ALG_WAIT: if (!stall)   nxt = ALG_RUN;
                ALG_DONE: if (done_clr) nxt = ALG_IDLE;
                default:  nxt = ALG_IDLE;
            endcase
        end
    end

    always_comb begin
        run     = 1'b0;
        waiting = 1'b0;
        done    = 1'b0;
        unique case (cur)
            ALG_IDLE: ;
            ALG_RUN:  run     = 1'b1;
            ALG_WAIT: waiting = 1'b1;
            ALG_DONE: done    = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/eng_csr_unit.sv
module eng_csr_unit
    import eng_csr_pkg::*;
#(
    parameter int          ADDR_W   = 12,
    parameter int unsigned CTRL_OFF = 32'h20,
    parameter int unsigned STAT_OFF = 32'h08
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [63:0]          bus_wdata_i,
    output logic [63:0]          bus_rdata_o,
    input  logic [2:0]           eng_done_i,
    input  logic                 alg_stall_i,
    output logic [2:0]           eng_go_o,
    output logic [2:0]           eng_clr_o,
    output logic                 alg_notify_o,
    output logic                 irq_o
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFF);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFF);

    logic [WORD_W-1:0]  ctrl_q;
    csr_cmd_t           cmd;
    logic [NUM_DMA-1:0] dma_busy;
    logic [NUM_DMA-1:0] dma_done;
    logic               alg_run;
    logic               alg_wait;
    logic               alg_done;
    logic [WORD_W-1:0]  stat_word;

    ecs_ctrl_reg #(
        .ADDR_W   (ADDR_W),
        .CTRL_OFF (CTRL_OFF)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr_i),
        .bus_addr  (bus_addr_i),
        .bus_wdata (bus_wdata_i),
        .ctrl_q    (ctrl_q),
        .cmd       (cmd),
        .go_q      (eng_go_o),
        .clr_q     (eng_clr_o)
    );

    for (genvar d = 0; d < NUM_DMA; d++) begin : g_dma
        ecs_dma_track u_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .go      (cmd.go[d]),
            .clr     (cmd.clr[d]),
            .done_ev (eng_done_i[d]),
            .rearm   (cmd.rearm),
            .busy    (dma_busy[d]),
            .done    (dma_done[d])
        );
    end

    ecs_alg_track u_alg (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (cmd.go[ALG_IDX]),
        .clr       (cmd.clr[ALG_IDX]),
        .done_clr  (cmd.done_clr),
        .done_ev   (eng_done_i[ALG_IDX]),
        .stall     (alg_stall_i),
        .rearm     (cmd.rearm),
        .notify_en (ctrl_q[C_ALG_NEN]),
        .run       (alg_run),
        .waiting   (alg_wait),
        .done      (alg_done),
        .notify    (alg_notify_o)
    );

    always_comb begin
        stat_word = '0;
        for (int d = 0; d < NUM_DMA; d++) begin
            stat_word[S_DMA_BUSY_BASE + S_DMA_STRIDE*d] = dma_busy[d];
            stat_word[S_DMA_DONE_BASE + S_DMA_STRIDE*d] = dma_done[d];
        end
        stat_word[S_ALG_WAIT] = alg_wait;
        stat_word[S_ALG_RUN]  = alg_run;
        stat_word[S_ALG_DONE] = alg_done;
    end

    always_comb begin
        if (bus_addr_i == CTRL_A)      bus_rdata_o = ctrl_q;
        else if (bus_addr_i == STAT_A) bus_rdata_o = stat_word;
        else                           bus_rdata_o = '0;
    end

    assign irq_o = (|(dma_done & ctrl_q[C_DMA_IEN_BASE +: NUM_DMA]))
                 | (alg_done & ctrl_q[C_ALG_IEN]);

endmodule

// File: rtl/ecs_checker.sv
module ecs_checker
    import eng_csr_pkg::*;
#(
    parameter int          ADDR_W   = 12,
    parameter int unsigned CTRL_OFF = 32'h20
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr_i,
    input logic [ADDR_W-1:0]  bus_addr_i,
    input logic [63:0]        bus_wdata_i,
    input logic [2:0]         eng_go_o,
    input logic [NUM_DMA-1:0] dma_busy,
    input logic [NUM_DMA-1:0] dma_done,
    input logic               alg_run,
    input logic               alg_wait,
    input logic               alg_done,
    input logic               alg_notify_o,
    input logic               irq_o
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFF);

    logic cw;
    assign cw = bus_wr_i && (bus_addr_i == CTRL_A);

    assert_go_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_go_o[0] |-> $past(cw && bus_wdata_i[C_GO_BASE]));

    assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_done[0] && !(cw && (bus_wdata_i[C_REARM] || bus_wdata_i[C_CLR_BASE])))
        |=> dma_done[0]);

    assert_alg_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({alg_run, alg_wait, alg_done}));

    assert_no_irq_without_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !((|dma_done) || alg_done) |-> !irq_o);

    assert_notify_on_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        alg_notify_o |-> (alg_done && !$past(alg_done)));

    assert_rearm_idles_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cw && bus_wdata_i[C_REARM])
        |=> (dma_busy == '0 && dma_done == '0 && !alg_run && !alg_wait && !alg_done));

endmodule

bind eng_csr_unit ecs_checker #(
    .ADDR_W   (ADDR_W),
    .CTRL_OFF (CTRL_OFF)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr_i     (bus_wr_i),
    .bus_addr_i   (bus_addr_i),
    .bus_wdata_i  (bus_wdata_i),
    .eng_go_o     (eng_go_o),
    .dma_busy     (dma_busy),
    .dma_done     (dma_done),
    .alg_run      (alg_run),
    .alg_wait     (alg_wait),
    .alg_done     (alg_done),
    .alg_notify_o (alg_notify_o),
    .irq_o        (irq_o)
);

// File: tb/sim_eng_csr_unit.sv
`timescale 1ns/1ps
module sim_eng_csr_unit;

    localparam logic [11:0] A_CTRL = 12'h020;
    localparam logic [11:0] A_STAT = 12'h008;
    localparam logic [11:0] A_OTHR = 12'h100;
    localparam logic [63:0] KEEP   = 64'h0000_6C00_0FF0_01F3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic [11:0] bus_addr_i = '0;
    logic [63:0] bus_wdata_i = '0;
    logic [63:0] bus_rdata_o;
    logic [2:0]  eng_done_i = '0;
    logic        alg_stall_i = 1'b0;
    logic [2:0]  eng_go_o;
    logic [2:0]  eng_clr_o;
    logic        alg_notify_o;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // model: dma 0 idle 1 busy 2 done; alg 0 idle 1 run 2 wait 3 done
    int          m_dma [2];
    int          m_alg;
    logic [63:0] m_ctrl;

    always #5 clk = ~clk;

    eng_csr_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .eng_done_i(eng_done_i),
        .alg_stall_i(alg_stall_i), .eng_go_o(eng_go_o), .eng_clr_o(eng_clr_o),
        .alg_notify_o(alg_notify_o), .irq_o(irq_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int f_dma(int s, bit go, bit clr, bit dn, bit rearm);
        if (rearm) return 0;
        if (dn) return 2;
        if (clr) return 0;
        if (s == 0 && go) return 1;
        return s;
    endfunction

    function automatic int f_alg(int s, bit go, bit clr, bit dclr, bit dn, bit stall, bit rearm);
        if (rearm) return 0;
        if (dn) return 3;
        if (clr) return 0;
        case (s)
            0: return go ? (stall ? 2 : 1) : 0;
            1: return stall ? 2 : 1;
            2: return stall ? 2 : 1;
            default: return dclr ? 0 : 3;
        endcase
    endfunction

    function automatic logic [63:0] f_status();
        logic [63:0] w = '0;
        w[41] = (m_dma[0] == 1); w[42] = (m_dma[0] == 2);
        w[44] = (m_dma[1] == 1); w[45] = (m_dma[1] == 2);
        w[47] = (m_alg == 1);    w[46] = (m_alg == 2);   w[48] = (m_alg == 3);
        return w;
    endfunction

    function automatic bit f_irq();
        return (m_dma[0] == 2 && m_ctrl[42]) || (m_dma[1] == 2 && m_ctrl[43])
            || (m_alg == 3 && m_ctrl[46]);
    endfunction

    // one clock step: inputs at negedge, outputs checked at the next negedge
    task automatic step(input bit wr, input logic [11:0] addr, input logic [63:0] wd,
                        input logic [2:0] dn, input bit stall, input string tag);
        bit          cw = wr && (addr == A_CTRL);
        logic [2:0]  e_go  = cw ? wd[38:36] : 3'b000;
        logic [2:0]  e_clr = cw ? wd[41:39] : 3'b000;
        bit          rearm = cw && wd[33];
        bit          dclr  = cw && wd[51];
        int          a_nxt;
        bit          e_ntf;
        bus_wr_i = wr; bus_addr_i = addr; bus_wdata_i = wd;
        eng_done_i = dn; alg_stall_i = stall;
        a_nxt = f_alg(m_alg, e_go[2], e_clr[2], dclr, dn[2], stall, rearm);
        e_ntf = (a_nxt == 3) && (m_alg != 3) && m_ctrl[45];
        @(posedge clk);
        for (int d = 0; d < 2; d++) m_dma[d] = f_dma(m_dma[d], e_go[d], e_clr[d], dn[d], rearm);
        m_alg = a_nxt;
        if (cw) m_ctrl = wd & KEEP;
        @(negedge clk);
        chk(eng_go_o == e_go, "R3", {tag, " go pulses"}, 64'(eng_go_o), 64'(e_go));
        chk(eng_clr_o == e_clr, "R6", {tag, " clear pulses"}, 64'(eng_clr_o), 64'(e_clr));
        chk(alg_notify_o == e_ntf, "R10", {tag, " notify"}, 64'(alg_notify_o), 64'(e_ntf));
        bus_wr_i = 1'b0; eng_done_i = '0; bus_addr_i = A_STAT;
        #1;
        chk(bus_rdata_o == f_status(), "R5", {tag, " status word"}, bus_rdata_o, f_status());
        chk(irq_o == f_irq(), "R9", {tag, " irq"}, 64'(irq_o), 64'(f_irq()));
        bus_addr_i = A_CTRL;
        #1;
        chk(bus_rdata_o == m_ctrl, "R2", {tag, " control readback"}, bus_rdata_o, m_ctrl);
    endtask

    function automatic logic [63:0] bits(input int b0, input int b1 = -1);
        logic [63:0] w = KEEP;
        w[b0] = 1'b1;
        if (b1 >= 0) w[b1] = 1'b1;
        return w;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        m_dma[0] = 0; m_dma[1] = 0; m_alg = 0; m_ctrl = '0;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_addr_i = A_CTRL; #1;
        chk(bus_rdata_o == 64'h0, "R1", "control after reset", bus_rdata_o, 64'h0);
        bus_addr_i = A_STAT; #1;
        chk(bus_rdata_o == 64'h0, "R1", "status after reset", bus_rdata_o, 64'h0);
        chk({eng_go_o, eng_clr_o, alg_notify_o, irq_o} == 8'h0, "R1", "outputs after reset",
            64'({eng_go_o, eng_clr_o, alg_notify_o, irq_o}), 64'h0);

        // R2 storage fields, all-ones write (rearm wins, R11)
        step(1, A_CTRL, '1, 3'b000, 0, "R2 all-ones");
        step(1, A_CTRL, KEEP, 3'b000, 0, "R2 storage");
        // R3/R4 read-DMA start, busy
        step(1, A_CTRL, bits(36), 3'b000, 0, "R3 rd go");
        step(0, A_STAT, '0, 3'b000, 0, "R4 rd busy");
        step(1, A_CTRL, bits(36), 3'b000, 0, "R4 go while busy");
        // R5 done sticky, R9 irq
        step(0, A_STAT, '0, 3'b001, 0, "R5 rd done");
        step(0, A_STAT, '0, 3'b000, 0, "R5 rd sticky");
        step(1, A_CTRL, bits(39), 3'b000, 0, "R6 rd clear");
        // R5 go+done same cycle, R6 done beats clear
        step(1, A_CTRL, bits(37), 3'b010, 0, "R5 wr go+done");
        step(1, A_CTRL, bits(40), 3'b010, 0, "R6 clear+done");
        step(1, A_CTRL, bits(40), 3'b000, 0, "R6 wr clear");
        // R8 algorithm running/waiting
        step(1, A_CTRL, bits(38), 3'b000, 1, "R8 alg go stalled");
        step(0, A_STAT, '0, 3'b000, 0, "R8 alg unstall");
        step(0, A_STAT, '0, 3'b000, 1, "R8 alg stall");
        step(0, A_STAT, '0, 3'b100, 0, "R10 alg done");
        // R7 done-clear
        step(1, A_CTRL, bits(51), 3'b000, 0, "R7 done clear");
        step(1, A_CTRL, bits(38), 3'b000, 0, "R7 alg go");
        step(1, A_CTRL, bits(51), 3'b000, 0, "R7 dclr while running");
        step(0, A_STAT, '0, 3'b100, 0, "R7 done again");
        // R11 rearm beats done
        step(1, A_CTRL, bits(36), 3'b000, 0, "R11 rd go");
        step(1, A_CTRL, bits(33), 3'b011, 0, "R11 rearm");
        // R12 other offsets ignored
        step(1, A_STAT, 64'hFFFF_FFFF_FFFF_FFFF, 3'b000, 0, "R12 write status offset");
        step(1, A_OTHR, 64'hFFFF_FFFF_FFFF_FFFF, 3'b000, 0, "R12 write unmapped");
        bus_addr_i = A_OTHR; #1;
        chk(bus_rdata_o == 64'h0, "R12", "unmapped read", bus_rdata_o, 64'h0);
        // R9 enables off
        step(1, A_CTRL, 64'h0, 3'b000, 0, "R9 enables off");
        step(0, A_STAT, '0, 3'b111, 0, "R9 done without enable");
        step(1, A_CTRL, KEEP, 3'b000, 0, "R9 enable after done");
        step(1, A_CTRL, bits(33, 39), 3'b000, 0, "R11 rearm with clear");

        // random stimulus
        for (int i = 0; i < 600; i++) begin
            logic [63:0] wd = {$urandom, $urandom} & KEEP;
            int          r = $urandom_range(0, 9);
            logic [11:0] ad = (r < 7) ? A_CTRL : (r < 8 ? A_STAT : A_OTHR);
            logic [2:0]  dn;
            for (int e = 0; e < 3; e++) begin
                wd[36+e] = ($urandom_range(0, 4) == 0);
                wd[39+e] = ($urandom_range(0, 7) == 0);
                dn[e]    = ($urandom_range(0, 5) == 0);
            end
            wd[51] = ($urandom_range(0, 5) == 0);
            wd[33] = ($urandom_range(0, 15) == 0);
            step($urandom_range(0, 1), ad, wd, dn, ($urandom_range(0, 3) == 0), "RND");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule